// File: doc/BRIEF.md
# Staged-Divisor Serial Oversample Clock Generator

This block derives the timing strobes for a serial transmitter and receiver from the bus clock. A 13-bit divisor sets how many bus cycles lie between two oversample strobes. Every sixteenth oversample strobe is also marked as a bit strobe, so the bit rate equals the bus clock divided by sixteen times the divisor.

Software writes the divisor as two bytes on a simple write port. A write to the upper byte only loads a staging register. The working divisor changes only when the lower byte is written, and both halves then take effect on the same edge. The oversample and bit counters restart from zero on that edge, so the first period after a change has exactly the new length.

The generator stays silent in three cases: while both the transmit enable and the receive enable are low, while the divisor is zero, and from reset until an enable is first raised. A read port returns the working divisor. The upper byte also carries two stored flag bits and a reserved bit that reads as zero.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the lower byte reads 0x04, the upper byte reads 0x00, and `osr_tick` and `bit_tick` are low.
- R2: A write with `wr_sel`=0 (upper byte) loads only the staging register. The working divisor, the upper-byte read value (bits 4:0) and the tick timing stay unchanged.
- R3: A write with `wr_sel`=1 (lower byte) makes the working divisor {staged bits 4:0, `wr_data`[7:0]} in one step. Both reads show the new value in the following cycle.
- R4: With working divisor D in 1..8191 and the generator running, `osr_tick` is high once every D cycles. It is high in every cycle for D=1 and for exactly one cycle for D of 2 or more.
- R5: While the working divisor is 0, neither tick is ever high, whatever the enables are.
- R6: The enables are sampled on each clock edge. While both are low, the counters are held at zero and no tick appears. Either enable alone starts the generator. The first `osr_tick` is high in the D-th cycle after the edge that first samples an enable high.
- R7: `bit_tick` is high exactly with every sixteenth `osr_tick`, counted from the last restart or enable. It is never high without `osr_tick`.
- R8: A lower-byte write restarts both counters, even in the middle of a period. The first `osr_tick` comes in the D-th cycle after the write edge, and the first `bit_tick` in the (16*D)-th cycle. A tick due in the cycle of the write still appears.
- R9: The upper-byte read gives the following fields:
  - bits 7:6: the flag bits of the last upper-byte write, which take effect immediately;
  - bit 5: always 0;
  - bits 4:0: working divisor bits 12:8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 1 | Write target: 0 upper byte (staged), 1 lower byte (commit) |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read select: 0 upper byte, 1 lower byte |
| rd_data | output | 8 | Read data of the selected byte (combinational) |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| osr_tick | output | 1 | Oversample strobe, one per divisor period |
| bit_tick | output | 1 | Bit strobe, every sixteenth oversample strobe |

## Verification
Two events can fall in the same cycle: a lower-byte commit, and the terminal count of the oversample counter (which is also the sixteenth strobe of the bit counter). The bench provokes this by issuing the commit in the very cycle an expected strobe fires. It also commits two cycles after a strobe, when the counter is partway through a period, and four strobes into a bit period. The scoreboard then requires three things: the strobe of the commit cycle is still seen, the next strobe arrives exactly one new divisor later, and the next bit strobe arrives sixteen new periods after the commit, with no strobe at the old spacing.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int DIV_W  = 13;
  localparam int BYTE_W = 8;
  localparam int FLAG_W = 2;
  localparam int OSR    = 16;
  localparam logic [BYTE_W-1:0] LO_RST = 8'h04;
endpackage

// File: rtl/baud_regs.sv
module baud_regs #(
  parameter int DIV_W  = baud_pkg::DIV_W,
  parameter int BYTE_W = baud_pkg::BYTE_W,
  parameter int FLAG_W = baud_pkg::FLAG_W,
  parameter logic [BYTE_W-1:0] LO_RST = baud_pkg::LO_RST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [BYTE_W-1:0] rd_data,
  output logic [DIV_W-1:0]  div_o,
  output logic              commit_o
);
  localparam int HI_W  = DIV_W - BYTE_W;
  localparam int PAD_W = BYTE_W - FLAG_W - HI_W;

  logic [HI_W-1:0]   stage_q, stage_d;
  logic [FLAG_W-1:0] flag_q, flag_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              wr_hi, wr_lo;
  logic [BYTE_W-1:0] hi_view;

  assign wr_hi = wr_en & ~wr_sel;
  assign wr_lo = wr_en &  wr_sel;

  always_comb begin
    stage_d = stage_q;
    flag_d  = flag_q;
    div_d   = div_q;
    if (wr_hi) begin
      stage_d = wr_data[HI_W-1:0];
      flag_d  = wr_data[BYTE_W-1 -: FLAG_W];
    end
    if (wr_lo) begin
      div_d = {stage_q, wr_data};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      flag_q  <= '0;
      div_q   <= {{HI_W{1'b0}}, LO_RST};
    end else begin
      if (wr_hi) begin
        stage_q <= stage_d;
        flag_q  <= flag_d;
      end
      if (wr_lo) begin
        div_q <= div_d;
      end
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign hi_view = {flag_q, {PAD_W{1'b0}}, div_q[DIV_W-1:BYTE_W]};
    end else begin : g_nopad
      assign hi_view = {flag_q, div_q[DIV_W-1:BYTE_W]};
    end
  endgenerate

  assign rd_data  = rd_sel ? div_q[BYTE_W-1:0] : hi_view;
  assign div_o    = div_q;
  assign commit_o = wr_lo;
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int DIV_W = baud_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             terminal;

  assign terminal = (cnt_q == DIV_W'(div - 1'b1));
  assign tick     = run & terminal;

  always_comb begin
    if (!run || restart) begin
      cnt_d = '0;
    end else if (terminal) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/baud_bitdiv.sv
module baud_bitdiv #(
  parameter int OSR = baud_pkg::OSR
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic osr_tick,
  output logic bit_tick
);
  localparam int OSR_W = $clog2(OSR);

  logic [OSR_W-1:0] bcnt_q, bcnt_d;
  logic             last;

  assign last     = (bcnt_q == OSR_W'(OSR - 1));
  assign bit_tick = osr_tick & last;

  always_comb begin
    if (!run || restart) begin
      bcnt_d = '0;
    end else if (osr_tick) begin
      bcnt_d = last ? '0 : bcnt_q + 1'b1;
    end else begin
      bcnt_d = bcnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
    end else begin
      bcnt_q <= bcnt_d;
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int DIV_W  = baud_pkg::DIV_W,
  parameter int BYTE_W = baud_pkg::BYTE_W,
  parameter int OSR    = baud_pkg::OSR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              tx_en,
  input  logic              rx_en,
  output logic              osr_tick,
  output logic              bit_tick
);
  logic [1:0]       sync_q;
  logic             rst_sync_n;
  logic             en_q, en_d;
  logic             run;
  logic             commit;
  logic [DIV_W-1:0] div_work;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = sync_q[1];

  assign en_d = tx_en | rx_en;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

  assign run = en_q & (div_work != '0);

  baud_regs #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .div_o    (div_work),
    .commit_o (commit)
  );

  baud_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (run),
    .restart (commit),
    .div     (div_work),
    .tick    (osr_tick)
  );

  baud_bitdiv #(.OSR(OSR)) u_bit (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run),
    .restart  (commit),
    .osr_tick (osr_tick),
    .bit_tick (bit_tick)
  );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int DIV_W  = baud_pkg::DIV_W,
  parameter int BYTE_W = baud_pkg::BYTE_W
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [BYTE_W-1:0] wr_data,
  input logic              rd_sel,
  input logic [BYTE_W-1:0] rd_data,
  input logic              tx_en,
  input logic              rx_en,
  input logic [DIV_W-1:0]  div_work,
  input logic              osr_tick,
  input logic              bit_tick
);
  p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !wr_sel) |=> $stable(div_work));

  p_commit_low_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_sel) |=> (div_work[BYTE_W-1:0] == $past(wr_data)));

  p_single_cycle_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (osr_tick && (div_work > 1) && !(wr_en && wr_sel)) |=> !osr_tick);

  p_zero_div_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (div_work == '0) |-> !osr_tick);

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!tx_en && !rx_en) |=> !osr_tick);

  p_bit_in_osr_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bit_tick |-> osr_tick);

  p_restart_bit_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_sel) |=> !bit_tick);

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_sel |-> !rd_data[5]);
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .rd_sel     (rd_sel),
  .rd_data    (rd_data),
  .tx_en      (tx_en),
  .rx_en      (rx_en),
  .div_work   (div_work),
  .osr_tick   (osr_tick),
  .bit_tick   (bit_tick)
);

// File: tb/test_baud_tick_gen.sv
`timescale 1ns/1ps
module test_baud_tick_gen;
  localparam int CLK_NS = 20;

  logic       clk;
  logic       rst_n;
  logic       wr_en, wr_sel, rd_sel, tx_en, rx_en;
  logic [7:0] wr_data, rd_data;
  logic       osr_tick, bit_tick;

  int checks, errors, spurious, cyc;
  int oq[$];
  int bq[$];
  string tag;

  baud_tick_gen i_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .tx_en(tx_en), .rx_en(rx_en),
    .osr_tick(osr_tick), .bit_tick(bit_tick)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Scoreboard monitor: pops expected strobe cycles as the design produces them
  always @(negedge clk) begin
    while (oq.size() > 0 && oq[0] < cyc) begin
      checks++; errors++;
      $display("FAIL %s osr_tick missed: actual none, expected cycle %0d", tag, oq[0]);
      void'(oq.pop_front());
    end
    if (osr_tick === 1'b1) begin
      if (oq.size() > 0 && oq[0] == cyc) begin
        checks++; void'(oq.pop_front());
      end else spurious++;
    end
    while (bq.size() > 0 && bq[0] < cyc) begin
      checks++; errors++;
      $display("FAIL %s bit_tick missed: actual none, expected cycle %0d", tag, bq[0]);
      void'(bq.pop_front());
    end
    if (bit_tick === 1'b1) begin
      if (bq.size() > 0 && bq[0] == cyc) begin
        checks++; void'(bq.pop_front());
      end else spurious++;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic push(input int k, input int d, input int n, input int nb);
    for (int i = 1; i <= n; i++) oq.push_back(k + d * i);
    for (int j = 1; j <= nb; j++) bq.push_back(k + 16 * d * j);
  endtask

  task automatic wait_to(input int last);
    while (cyc < last) step();
  endtask

  task automatic bus_wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic sel, input logic [7:0] exp, input string t);
    rd_sel = sel; #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s read sel=%0d: actual %h expected %h", t, sel, rd_data, exp);
    end
  endtask

  int sp_mark;
  task automatic phase_end(input string t);
    checks++;
    if (spurious != sp_mark || oq.size() != 0 || bq.size() != 0) begin
      errors++;
      $display("FAIL %s strobes: actual %0d extra/%0d pending, expected 0/0",
               t, spurious - sp_mark, oq.size() + bq.size());
    end
    sp_mark = spurious;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout, expected completion");
    summary();
  end

  int k, last;
  initial begin
    checks = 0; errors = 0; spurious = 0; sp_mark = 0; tag = "R1";
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00;
    rd_sel = 1'b0; tx_en = 1'b0; rx_en = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (5) step();

    // R1: reset values
    rd_chk(1'b1, 8'h04, "R1");
    rd_chk(1'b0, 8'h00, "R1");
    checks++;
    if (osr_tick !== 1'b0 || bit_tick !== 1'b0) begin
      errors++; $display("FAIL R1 ticks: actual %b%b expected 00", osr_tick, bit_tick);
    end
    // R6: no strobes while both enables are low
    tag = "R6"; repeat (30) step(); phase_end("R6 idle");

    // R4/R7: default divisor 4, transmitter enable only
    tag = "R4"; k = cyc; push(k, 4, 20, 1); last = k + 80;
    tx_en = 1'b1;
    wait_to(last); phase_end("R4 R7 div4");

    // R2: staged upper byte leaves timing unchanged (bit counter at 4 of 16)
    tag = "R2"; k = cyc; push(k, 4, 16, 0); bq.push_back(k + 48); last = k + 64;
    bus_wr(1'b0, 8'h01);
    rd_chk(1'b0, 8'h00, "R2");
    wait_to(last); phase_end("R2 staged");

    // R8/R3: commit two cycles into a period, bit counter mid-way
    tag = "R8"; step(); step();
    k = cyc; push(k, 258, 17, 1); last = k + 17 * 258;
    bus_wr(1'b1, 8'h02);
    rd_chk(1'b1, 8'h02, "R3");
    rd_chk(1'b0, 8'h01, "R3");
    wait_to(last); phase_end("R8 R3 div258");

    // R6: disable, stage upper byte while idle, then receiver enable only
    tag = "R6"; tx_en = 1'b0;
    bus_wr(1'b0, 8'h00);
    repeat (40) step(); phase_end("R6 off");
    k = cyc; push(k, 258, 2, 0); last = k + 516;
    rx_en = 1'b1;
    wait_to(last); phase_end("R6 rx only");

    // R8/R4: commit divisor 1 in the cycle a strobe fires
    tag = "R4"; k = cyc; push(k, 1, 32, 2); last = k + 32;
    bus_wr(1'b1, 8'h01);
    wait_to(last); phase_end("R4 R8 div1");

    // R5: divisor 0 while enabled
    tag = "R5"; bus_wr(1'b1, 8'h00);
    repeat (100) step(); phase_end("R5 zero");

    // R9: flags immediate, reserved bit zero, divisor bits after commit
    tag = "R9"; bus_wr(1'b0, 8'hE5);
    rd_chk(1'b0, 8'hC0, "R9");
    k = cyc; push(k, 1283, 2, 0); last = k + 2 * 1283;
    bus_wr(1'b1, 8'h03);
    rd_chk(1'b0, 8'hC5, "R9");
    wait_to(last); phase_end("R9 div1283");

    // R4: largest divisor
    tag = "R4"; bus_wr(1'b0, 8'h1F);
    k = cyc; push(k, 8191, 2, 0); last = k + 2 * 8191;
    bus_wr(1'b1, 8'hFF);
    rd_chk(1'b0, 8'h1F, "R4");
    rd_chk(1'b1, 8'hFF, "R4");
    wait_to(last);
    rx_en = 1'b0;
    repeat (10) step(); phase_end("R4 div8191");

    summary();
  end
endmodule